// File: doc/BRIEF.md
# Double-Buffered Asynchronous Character Transmitter

This block turns parallel characters into frames on a single asynchronous serial line. It runs from a clock at sixteen times the bit rate. Every bit on the line, including the start bit, therefore lasts sixteen clocks. A character is written into a holding buffer while an active-low load strobe is low. When the strobe returns high, the character moves into the shift register, which sends a start bit, the data bits, an optional parity bit and one or more stop bits.

The format controls are captured by a level-sensitive strobe. They hold whatever value was present on the last clock that strobe was high, and they follow the pins for as long as it stays high. The controls are the character length (5 to 8 bits), parity inhibit, even/odd parity and long stop. Because of the two stages, a second character can be loaded while the first is still on the line. The second frame then begins on the clock after the first frame's last stop clock. Two flags tell the host when the holding buffer is free and when the line has gone fully idle.

Top module: `async_char_sender`

## Requirements
- R1: After reset, and whenever the shift register is empty, the serial line is high. Reset also sets both the buffer-empty flag and the register-empty flag high.
- R2: A frame begins with one low start bit, followed by the data least significant bit first. Each bit lasts 16 clocks.
- R3: The length code selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data inputs above the selected length have no effect on the line.
- R4: With parity inhibit low, one parity bit follows the last data bit. With the even select high, this bit makes the count of ones across data and parity even; with it low, the count is odd. With parity inhibit high, no parity bit is sent.
- R5: With long stop low, 1 stop bit (16 clocks) is sent. With it high, a 5-bit character gets 1.5 stop bits (24 clocks) and every other length gets 2 stop bits (32 clocks).
- R6: The holding buffer takes the data inputs on every clock where the load strobe is low. Data changes while the strobe is high are not sent. When the register is idle, the start bit appears on the first clock after the clock edge that samples the strobe high again.
- R7: A character loaded while a frame is being sent waits. Its start bit begins on the clock directly after the last stop clock of the current frame, with no idle clock between the two frames.
- R8: The buffer-empty flag is low from the first clock the strobe is sampled low until the character moves to the shift register. It is high from the move onward.
- R9: The register-empty flag is low from the start bit through the last clock of the final stop bit. It goes high on the clock after that last stop clock.
- R10: The format controls follow their pins while the control strobe is high. They keep the value from the last clock the strobe was high while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, 16 times the bit rate |
| rst | input | 1 | Synchronous master reset, active high |
| din | input | 8 | Parallel character data |
| load_n | input | 1 | Active-low buffer write strobe; rising edge requests transfer |
| fmt_strobe | input | 1 | Format capture strobe, transparent while high |
| len_sel | input | 2 | Character length code |
| par_off | input | 1 | Parity inhibit |
| par_even | input | 1 | Even parity when high, odd when low |
| long_stop | input | 1 | Selects 1.5 or 2 stop bits |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding buffer free |
| shift_empty | output | 1 | Shift register idle, last stop bit finished |

## Verification
The assertions assume that the load strobe is not pulsed again while an earlier transfer request is still waiting. They also assume that the strobe is high on the edge where a deferred transfer is taken. The stimulus respects both: it releases the second character early in the first frame and then leaves the strobe high until both frames have ended. The format controls are changed only through the control strobe between frames. The pins are then set to random values to show that the captured format holds.

// File: rtl/async_char_sender.sv
module async_char_sender #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] din,
  input  logic       load_n,
  input  logic       fmt_strobe,
  input  logic [1:0] len_sel,
  input  logic       par_off,
  input  logic       par_even,
  input  logic       long_stop,
  output logic       txd,
  output logic       hold_empty,
  output logic       shift_empty
);

  localparam int PW   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int FW   = 12;
  localparam int MAXC = OVS * FW;
  localparam int CW   = $clog2(MAXC + 1);

  logic [1:0]    c_len;
  logic          c_poff, c_even, c_long;
  logic [7:0]    hold_buf;
  logic          hold_full, pending, load_q, busy;
  logic [PW-1:0] phase;
  logic [CW-1:0] remain, total;
  logic [FW-1:0] sreg, frame;
  logic [3:0]    nbits;
  logic [7:0]    masked;
  logic          par_bit, rise, last, xfer_req, take;

  always_ff @(posedge clk) begin
    if (rst) {c_len, c_poff, c_even, c_long} <= 5'b11_1_0_0;
    else if (fmt_strobe) {c_len, c_poff, c_even, c_long} <= {len_sel, par_off, par_even, long_stop};
  end

  assign nbits    = 4'd5 + {2'b00, c_len};
  assign masked   = hold_buf & (8'hFF >> (2'd3 - c_len));
  assign par_bit  = c_even ? ^masked : ~^masked;
  assign rise     = load_n & ~load_q;
  assign last     = busy && (remain == CW'(1));
  assign xfer_req = rise | pending;
  assign take     = xfer_req & load_n & (~busy | last);

  always_comb begin
    int stop_c;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(nbits)) frame[i+1] = masked[i];
    if (!c_poff) frame[nbits + 4'd1] = par_bit;
    if (!c_long) stop_c = OVS;
    else if (c_len == 2'd0) stop_c = OVS + OVS / 2;
    else stop_c = 2 * OVS;
    total = CW'(OVS * (1 + int'(nbits) + (c_poff ? 0 : 1)) + stop_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q    <= 1'b1;
      hold_full <= 1'b0;
      pending   <= 1'b0;
      busy      <= 1'b0;
      phase     <= '0;
      remain    <= '0;
      sreg      <= '1;
      hold_buf  <= '0;
    end else begin
      load_q  <= load_n;
      pending <= xfer_req & ~take;
      if (!load_n) begin
        hold_buf  <= din;
        hold_full <= 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
      if (take) begin
        busy   <= 1'b1;
        sreg   <= frame;
        phase  <= '0;
        remain <= total;
      end else if (busy) begin
        phase  <= (phase == PW'(OVS - 1)) ? '0 : phase + PW'(1);
        if (phase == PW'(OVS - 1)) sreg <= {1'b1, sreg[FW-1:1]};
        remain <= remain - CW'(1);
        if (last) busy <= 1'b0;
      end
    end
  end

  assign txd         = ~busy | sreg[0];
  assign hold_empty  = ~hold_full;
  assign shift_empty = ~busy;

  AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (shift_empty && hold_empty && txd)); // R1
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst) shift_empty |-> txd); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst) $fell(shift_empty) |-> !txd); // R2
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst) load_n |=> $stable(hold_buf)); // R6
  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst) (last && xfer_req && load_n) |=> (!shift_empty && !txd)); // R7
  AST_BUF_FREED: assert property (@(posedge clk) disable iff (rst) take |=> hold_empty); // R8
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (rst) !fmt_strobe |=> $stable({c_len, c_poff, c_even, c_long})); // R10

endmodule

// File: tb/sim_async_char_sender.sv
module sim_async_char_sender;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic       load_n = 1'b1;
  logic       fmt_strobe = 1'b0;
  logic [1:0] len_sel = '0;
  logic       par_off = 1'b1, par_even = 1'b0, long_stop = 1'b0;
  logic       txd, hold_empty, shift_empty;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [1:0] g_len = 2'd3;
  logic       g_poff = 1'b1, g_even = 1'b0, g_long = 1'b0;

  async_char_sender u0 (
    .clk(clk), .rst(rst), .din(din), .load_n(load_n), .fmt_strobe(fmt_strobe),
    .len_sel(len_sel), .par_off(par_off), .par_even(par_even), .long_stop(long_stop),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int nb();
    return 5 + int'(g_len);
  endfunction

  function automatic int frame_clocks();
    int s;
    if (!g_long) s = 16;
    else if (g_len == 2'd0) s = 24;
    else s = 32;
    return 16 * (1 + nb() + (g_poff ? 0 : 1)) + s;
  endfunction

  function automatic int exp_bit(input logic [7:0] d, input int k);
    logic [7:0] m;
    m = d & (8'hFF >> (3 - int'(g_len)));
    if (k == 0) return 0;
    if (k <= nb()) return int'(m[k-1]);
    if (k == nb() + 1 && !g_poff) return g_even ? int'(^m) : int'(~^m);
    return 1;
  endfunction

  task automatic set_fmt(input logic [1:0] l, input logic po, input logic ev, input logic ls);
    @(negedge clk);
    len_sel = l; par_off = po; par_even = ev; long_stop = ls; fmt_strobe = 1'b1;
    g_len = l; g_poff = po; g_even = ev; g_long = ls;
    @(negedge clk);
    fmt_strobe = 1'b0;
    len_sel = 2'($urandom); par_off = 1'($urandom); par_even = 1'($urandom); long_stop = 1'($urandom);
  endtask

  task automatic send(input logic [7:0] a, input logic two, input logic [7:0] b);
    int t, lend;
    t = frame_clocks();
    lend = two ? 2 * t : t;
    @(negedge clk);
    din = a; load_n = 1'b0;
    @(negedge clk);
    chk("R8 buffer flag low after write", int'(hold_empty), 0);
    load_n = 1'b1; din = 8'($urandom);
    @(posedge clk);
    for (int i = 0; i <= lend; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk("R6 start right after strobe rise", int'(txd), 0);
        chk("R9 register flag low at start", int'(shift_empty), 0);
        chk("R8 buffer flag high after move", int'(hold_empty), 1);
      end
      if (i < t && (i % 16) == 8)
        chk("R2 R3 R4 R5 first frame bit", int'(txd), exp_bit(a, i / 16));
      if (two) begin
        if (i == 40) begin din = b; load_n = 1'b0; end
        if (i == 41) begin
          chk("R8 buffer flag low while waiting", int'(hold_empty), 0);
          load_n = 1'b1; din = 8'($urandom);
        end
        if (i == t - 1) chk("R8 buffer held until move", int'(hold_empty), 0);
        if (i == t) begin
          chk("R7 second start without gap", int'(txd), 0);
          chk("R7 register stays busy", int'(shift_empty), 0);
          chk("R8 buffer freed at move", int'(hold_empty), 1);
        end
        if (i >= t && i < lend && ((i - t) % 16) == 8)
          chk("R7 second frame bit", int'(txd), exp_bit(b, (i - t) / 16));
      end
      if (i == lend - 1) chk("R9 register busy on last stop clock", int'(shift_empty), 0);
      if (i == lend) begin
        chk("R9 register empty after stop", int'(shift_empty), 1);
        chk("R1 line idles high", int'(txd), 1);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 line high after reset", int'(txd), 1);
    chk("R1 buffer flag after reset", int'(hold_empty), 1);
    chk("R1 register flag after reset", int'(shift_empty), 1);
    repeat (18) @(negedge clk);

    set_fmt(2'd3, 1'b1, 1'b0, 1'b0);
    send(8'hA5, 1'b0, 8'h00);
    set_fmt(2'd0, 1'b1, 1'b0, 1'b1);
    send(8'hEB, 1'b0, 8'h00);
    set_fmt(2'd0, 1'b0, 1'b1, 1'b1);
    send(8'h1B, 1'b0, 8'h00);
    set_fmt(2'd1, 1'b0, 1'b0, 1'b0);
    send(8'hD2, 1'b0, 8'h00);
    set_fmt(2'd2, 1'b0, 1'b1, 1'b1);
    send(8'hFF, 1'b0, 8'h00);
    set_fmt(2'd3, 1'b0, 1'b0, 1'b1);
    send(8'h3C, 1'b1, 8'hC3);

    @(negedge clk);
    len_sel = 2'd1; par_off = 1'b0; par_even = 1'b1; long_stop = 1'b0; fmt_strobe = 1'b1;
    g_len = 2'd1; g_poff = 1'b0; g_even = 1'b1; g_long = 1'b0;
    send(8'h96, 1'b0, 8'h00);
    @(negedge clk);
    fmt_strobe = 1'b0;

    for (int r = 0; r < 30; r++) begin
      set_fmt(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      send(8'($urandom), ($urandom % 3) == 0, 8'($urandom));
      repeat (2 + ($urandom % 5)) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule